// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This block turns a vector of IEEE-754 double-precision values into signed 32-bit integers. Each 64-bit source lane gives one 32-bit result, and the results are packed side by side at the bottom of a 256-bit destination. A two-bit mode input chooses the operation. Two modes convert two lanes and differ in how they treat the upper destination bits. A third mode converts four lanes. The fourth encoding is reserved. Inexact values are rounded according to an external two-bit rounding-control field. Lanes that are out of range, NaN or infinite raise an invalid condition. When that condition is masked, the lane returns the indefinite integer 0x80000000.

The block reports only two condition flags, invalid and precision. Each is the OR over the active lanes. An unmasked invalid, or the reserved mode, raises `out_fault` and suppresses the whole destination write. The write-enable output has two bits: bit 0 covers destination bits [127:0] and bit 1 covers bits [255:128]. A single valid strobe moves an operation through the block. With the default `PIPE_STAGE = 1`, a two-state machine holds the registered result:
- States: `ST_EMPTY` (no result held) and `ST_LOADED` (result presented with `out_valid`).
- ACCEPT: `ST_EMPTY` to `ST_LOADED` on `in_valid`.
- REFILL: `ST_LOADED` to `ST_LOADED` on `in_valid`.
- DRAIN: `ST_LOADED` to `ST_EMPTY` without `in_valid`.
- IDLE: `ST_EMPTY` to `ST_EMPTY` without `in_valid`.

With `PIPE_STAGE = 0` the path is purely combinational.

Top module: `dcv_top`

## Requirements
- R1: Source lane i is `in_src[64*i+63:64*i]`, and its result goes to `out_dst[32*i+31:32*i]`. Destination bits above the active lanes that are not otherwise defined are zero.
- R2: The rounding control `in_rc` selects how inexact values round: 2'b00 rounds to nearest with ties to even, 2'b01 rounds toward negative infinity, 2'b10 rounds toward positive infinity and 2'b11 rounds toward zero.
- R3: `out_flag_pe` is the OR over active lanes that are not an integer and whose rounded value fits. An exact conversion does not raise it.
- R4: A lane is invalid when its input is NaN or infinity of either sign, or when its rounded value lies outside [-2^31, 2^31-1]. `out_flag_inv` is the OR of this over the active lanes, and a masked invalid lane returns 0x80000000. A lane that rounds to exactly -2^31 is valid.
- R5: Zero converts to 0 exactly. A nonzero subnormal converts to 0 and raises precision, except that it converts to -1 when negative under 2'b01 and to +1 when positive under 2'b10.
- R6: Mode 2'b00 converts lanes 0 and 1, drives `out_dst[255:64]` to zero and sets `out_we` to 2'b01, so the upper half is left unwritten.
- R7: Mode 2'b01 converts lanes 0 and 1, drives `out_dst[255:64]` to zero and sets `out_we` to 2'b11.
- R8: Mode 2'b10 converts lanes 0 to 3, drives `out_dst[255:128]` to zero and sets `out_we` to 2'b11.
- R9: In both two-lane modes, source bits [255:128] have no effect on the result or on the flags.
- R10: When `in_inv_mask` is 0 and any active lane is invalid, `out_fault` is 1 and `out_we` is 2'b00, while `out_dst` is zero and the flags are still reported.
- R11: Mode 2'b11 is reserved. It gives `out_fault` 1, `out_we` 2'b00 and both flags 0.
- R12: With `PIPE_STAGE = 1`, `out_valid` follows `in_valid` one cycle later. While `out_valid` is 0, `out_we`, both flags and `out_fault` are 0.
- R13: While `rst_n` is low, and after reset until the first accepted operation, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_mode | input | 2 | Lane mode: 00 two-lane keep-upper, 01 two-lane zero-upper, 10 four-lane, 11 reserved |
| in_rc | input | 2 | Rounding control |
| in_inv_mask | input | 1 | 1 masks invalid (indefinite returned) |
| in_src | input | 256 | Packed double-precision source lanes |
| out_valid | output | 1 | Result strobe |
| out_dst | output | 256 | Packed 32-bit results |
| out_we | output | 2 | Write enable: bit 0 for [127:0], bit 1 for [255:128] |
| out_flag_inv | output | 1 | Invalid flag (OR over active lanes) |
| out_flag_pe | output | 1 | Precision flag (OR over active lanes) |
| out_fault | output | 1 | Unmasked invalid or reserved mode |

## Verification
The bench targets the values at the edge of the range:
- 2147483647.5 becomes invalid when rounded up but not when truncated. A converter that tests the range before rounding misses that.
- -2147483648.5 truncates to a valid -2^31. A limit check written symmetrically would flag it wrongly.
- Ties such as 0.5, 1.5 and 2.5 expose a round-half-up mistake, because ties must go to even.
- Subnormals under directed rounding must produce ±1 rather than 0.

NaN is placed in the inactive upper lanes during two-lane modes, so a converter that ORs all four lanes would raise a false invalid. An unmasked invalid is checked to suppress both write-enable bits. The legacy mode is checked to keep the upper write-enable low. Random operands are compared lane by lane against a real-arithmetic reference model in all four rounding modes.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
    localparam int FP_W      = 64;
    localparam int EXP_W     = 11;
    localparam int MAN_W     = 52;
    localparam int EXP_BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int INT_W     = 32;
    localparam int MAX_LANES = 4;
    localparam int SRC_W     = FP_W * MAX_LANES;
    localparam int DST_W     = SRC_W;
    localparam int HALF_W    = DST_W / 2;
    localparam int NARROW_N  = MAX_LANES / 2;
    localparam int WE_W      = 2;
    localparam int SH_W      = MAN_W + 1 + FP_W;
    localparam int SHAMT_W   = $clog2(SH_W);
    localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RC_NEAR  = 2'b00,
        RC_DOWN  = 2'b01,
        RC_UP    = 2'b10,
        RC_TRUNC = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        MD_KEEP2 = 2'b00,
        MD_ZERO2 = 2'b01,
        MD_WIDE4 = 2'b10,
        MD_RSVD  = 2'b11
    } lane_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;
endpackage

// File: rtl/dcv_lane.sv
module dcv_lane
    import dcv_pkg::*;
(
    input  logic [FP_W-1:0]  fp_i,
    input  rnd_mode_e        rc_i,
    output logic [INT_W-1:0] int_o,
    output logic             inv_o,
    output logic             inx_o
);
    localparam logic [INT_W+1:0] NEG_LIM = {2'b00, 1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W+1:0] POS_LIM = NEG_LIM - 1'b1;

    logic               sgn;
    logic [EXP_W-1:0]   bexp;
    logic [MAN_W-1:0]   frac;
    int                 uexp;
    logic               is_special;
    logic               is_zero;
    logic               is_tiny;
    logic               is_huge;
    logic [SHAMT_W-1:0] shamt;
    logic [SH_W-1:0]    shifted;
    logic [INT_W:0]     mag;
    logic               hi_lost;
    logic               rbit;
    logic               sbit;
    logic               inc;
    logic [INT_W+1:0]   mag_r;
    logic               fits;

    assign {sgn, bexp, frac} = fp_i;

    // Classification of the operand
    always_comb begin
        uexp       = int'(bexp) - EXP_BIAS;
        is_special = &bexp;
        is_zero    = (bexp == '0) && (frac == '0);
        is_tiny    = !is_zero && ((bexp == '0) || (uexp < -1));
        is_huge    = !is_special && (uexp > INT_W - 1);
    end

    // Align the significand: integer part above FP_W, fraction below
    always_comb begin
        shamt   = '0;
        shifted = '0;
        if (!is_special && !is_zero && !is_tiny && !is_huge) begin
            shamt   = SHAMT_W'(MAN_W - uexp);
            shifted = {1'b1, frac, {FP_W{1'b0}}} >> shamt;
        end
        mag     = shifted[FP_W +: INT_W+1];
        hi_lost = |shifted[SH_W-1 : FP_W+INT_W+1];
        rbit    = shifted[FP_W-1];
        sbit    = (|shifted[FP_W-2:0]) | is_tiny;
    end

    // Rounding increment selected by the control field
    always_comb begin
        unique case (rc_i)
            RC_NEAR:  inc = rbit & (sbit | mag[0]);
            RC_DOWN:  inc = sgn & (rbit | sbit);
            RC_UP:    inc = ~sgn & (rbit | sbit);
            RC_TRUNC: inc = 1'b0;
            default:  inc = 1'b0;
        endcase
    end

    // Range test after rounding and final result
    always_comb begin
        mag_r = {1'b0, mag} + {{(INT_W+1){1'b0}}, inc};
        fits  = !hi_lost && (sgn ? (mag_r <= NEG_LIM) : (mag_r <= POS_LIM));
        inv_o = is_special | is_huge | !fits;
        inx_o = !inv_o & (rbit | sbit);
        if (inv_o)
            int_o = INDEF;
        else if (sgn)
            int_o = (~mag_r[INT_W-1:0]) + 1'b1;
        else
            int_o = mag_r[INT_W-1:0];
    end
endmodule

// File: rtl/dcv_pack.sv
module dcv_pack
    import dcv_pkg::*;
(
    input  lane_mode_e                 mode_i,
    input  logic                       inv_mask_i,
    input  logic [MAX_LANES*INT_W-1:0] res_i,
    input  logic [MAX_LANES-1:0]       inv_i,
    input  logic [MAX_LANES-1:0]       inx_i,
    output logic [DST_W-1:0]           dst_o,
    output logic [WE_W-1:0]            we_o,
    output logic                       inv_o,
    output logic                       pe_o,
    output logic                       fault_o
);
    localparam int PACK_W = MAX_LANES * INT_W;

    logic [MAX_LANES-1:0] lane_act;
    logic [PACK_W-1:0]    packed_res;
    logic                 any_inv;
    logic                 any_pe;
    logic                 rsvd;

    // Lanes in the low half are live in every legal mode, the rest only wide
    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        if (g < NARROW_N) begin : g_low
            assign lane_act[g] = (mode_i != MD_RSVD);
        end else begin : g_high
            assign lane_act[g] = (mode_i == MD_WIDE4);
        end
        assign packed_res[g*INT_W +: INT_W] = lane_act[g] ? res_i[g*INT_W +: INT_W] : '0;
    end

    always_comb begin
        rsvd    = (mode_i == MD_RSVD);
        any_inv = |(inv_i & lane_act);
        any_pe  = |(inx_i & lane_act);
        fault_o = rsvd | (any_inv & ~inv_mask_i);
        inv_o   = any_inv;
        pe_o    = any_pe;
        if (fault_o) begin
            dst_o = '0;
            we_o  = '0;
        end else begin
            dst_o = {{(DST_W-PACK_W){1'b0}}, packed_res};
            unique case (mode_i)
                MD_KEEP2: we_o = 2'b01;
                MD_ZERO2: we_o = 2'b11;
                MD_WIDE4: we_o = 2'b11;
                default:  we_o = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/dcv_top.sv
module dcv_top
    import dcv_pkg::*;
#(
    parameter int PIPE_STAGE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic [1:0]       in_rc,
    input  logic             in_inv_mask,
    input  logic [SRC_W-1:0] in_src,
    output logic             out_valid,
    output logic [DST_W-1:0] out_dst,
    output logic [WE_W-1:0]  out_we,
    output logic             out_flag_inv,
    output logic             out_flag_pe,
    output logic             out_fault
);
    lane_mode_e                 mode_c;
    rnd_mode_e                  rc_c;
    logic [MAX_LANES*INT_W-1:0] lane_res;
    logic [MAX_LANES-1:0]       lane_inv;
    logic [MAX_LANES-1:0]       lane_inx;
    logic [DST_W-1:0]           c_dst;
    logic [WE_W-1:0]            c_we;
    logic                       c_inv;
    logic                       c_pe;
    logic                       c_fault;

    assign mode_c = lane_mode_e'(in_mode);
    assign rc_c   = rnd_mode_e'(in_rc);

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_cvt
        dcv_lane u_lane (
            .fp_i  (in_src[g*FP_W +: FP_W]),
            .rc_i  (rc_c),
            .int_o (lane_res[g*INT_W +: INT_W]),
            .inv_o (lane_inv[g]),
            .inx_o (lane_inx[g])
        );
    end

    dcv_pack u_pack (
        .mode_i     (mode_c),
        .inv_mask_i (in_inv_mask),
        .res_i      (lane_res),
        .inv_i      (lane_inv),
        .inx_i      (lane_inx),
        .dst_o      (c_dst),
        .we_o       (c_we),
        .inv_o      (c_inv),
        .pe_o       (c_pe),
        .fault_o    (c_fault)
    );

    if (PIPE_STAGE != 0) begin : g_piped
        stage_state_e     state_q;
        stage_state_e     state_d;
        logic [DST_W-1:0] dst_q;
        logic [WE_W-1:0]  we_q;
        logic             inv_q;
        logic             pe_q;
        logic             fault_q;

        // Next-state logic: ACCEPT, REFILL, DRAIN, IDLE
        always_comb begin
            unique case (state_q)
                ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
                ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
                default:   state_d = ST_EMPTY;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                state_q <= ST_EMPTY;
            else
                state_q <= state_d;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dst_q   <= '0;
                we_q    <= '0;
                inv_q   <= 1'b0;
                pe_q    <= 1'b0;
                fault_q <= 1'b0;
            end else if (in_valid) begin
                dst_q   <= c_dst;
                we_q    <= c_we;
                inv_q   <= c_inv;
                pe_q    <= c_pe;
                fault_q <= c_fault;
            end
        end

        // Output process: strobes only live in ST_LOADED
        always_comb begin
            out_valid    = (state_q == ST_LOADED);
            out_dst      = dst_q;
            out_we       = out_valid ? we_q : '0;
            out_flag_inv = out_valid & inv_q;
            out_flag_pe  = out_valid & pe_q;
            out_fault    = out_valid & fault_q;
        end

        // R12
        valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R12
        valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R11
        rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b11) |=> (out_fault && out_we == 2'b00));
        // R6
        keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_mode == 2'b00 && in_inv_mask) |=> (out_we == 2'b01));
    end else begin : g_comb
        always_comb begin
            out_valid    = in_valid;
            out_dst      = c_dst;
            out_we       = in_valid ? c_we : '0;
            out_flag_inv = in_valid & c_inv;
            out_flag_pe  = in_valid & c_pe;
            out_fault    = in_valid & c_fault;
        end
    end

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_we == '0 && !out_flag_inv && !out_flag_pe && !out_fault));
    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dst[DST_W-1:HALF_W] == '0));
    // R10
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault) |-> (out_we == '0 && out_dst == '0));
endmodule

// File: tb/dcv_top_tb_top.sv
`timescale 1ns/1ps
module dcv_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_mode = 2'b00;
    logic [1:0]   in_rc = 2'b00;
    logic         in_inv_mask = 1'b1;
    logic [255:0] in_src = '0;
    logic         out_valid;
    logic [255:0] out_dst;
    logic [1:0]   out_we;
    logic         out_flag_inv;
    logic         out_flag_pe;
    logic         out_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dcv_top #(.PIPE_STAGE(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_rc(in_rc), .in_inv_mask(in_inv_mask), .in_src(in_src),
        .out_valid(out_valid), .out_dst(out_dst), .out_we(out_we),
        .out_flag_inv(out_flag_inv), .out_flag_pe(out_flag_pe), .out_fault(out_fault)
    );

    localparam logic [63:0] D_NAN  = 64'h7FF8000000000000;
    localparam logic [63:0] D_ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] D_M2   = 64'hC000000000000000;
    localparam logic [63:0] D_3    = 64'h4008000000000000;
    localparam logic [63:0] D_M7   = 64'hC01C000000000000;
    localparam logic [63:0] D_HALF = 64'h3FE0000000000000;

    // {rc, source, expected int, expected invalid, expected precision}
    localparam int NV = 22;
    localparam logic [99:0] VTAB [0:NV-1] = '{
        {2'd0, 64'h3FE0000000000000, 32'h00000000, 1'b0, 1'b1},
        {2'd0, 64'h3FF8000000000000, 32'h00000002, 1'b0, 1'b1},
        {2'd0, 64'h4004000000000000, 32'h00000002, 1'b0, 1'b1},
        {2'd0, 64'hBFF8000000000000, 32'hFFFFFFFE, 1'b0, 1'b1},
        {2'd1, 64'hBFE0000000000000, 32'hFFFFFFFF, 1'b0, 1'b1},
        {2'd2, 64'h3FE0000000000000, 32'h00000001, 1'b0, 1'b1},
        {2'd3, 64'hBFF8000000000000, 32'hFFFFFFFF, 1'b0, 1'b1},
        {2'd0, 64'h41E0000000000000, 32'h80000000, 1'b1, 1'b0},
        {2'd0, 64'hC1E0000000000000, 32'h80000000, 1'b0, 1'b0},
        {2'd3, 64'h41DFFFFFFFC00000, 32'h7FFFFFFF, 1'b0, 1'b0},
        {2'd2, 64'h41DFFFFFFFE00000, 32'h80000000, 1'b1, 1'b0},
        {2'd3, 64'h41DFFFFFFFE00000, 32'h7FFFFFFF, 1'b0, 1'b1},
        {2'd1, 64'hC1E0000000100000, 32'h80000000, 1'b1, 1'b0},
        {2'd3, 64'hC1E0000000100000, 32'h80000000, 1'b0, 1'b1},
        {2'd0, 64'h7FF8000000000000, 32'h80000000, 1'b1, 1'b0},
        {2'd3, 64'hFFF0000000000000, 32'h80000000, 1'b1, 1'b0},
        {2'd2, 64'h0000000000000001, 32'h00000001, 1'b0, 1'b1},
        {2'd1, 64'h8000000000000001, 32'hFFFFFFFF, 1'b0, 1'b1},
        {2'd0, 64'h8000000000000001, 32'h00000000, 1'b0, 1'b1},
        {2'd1, 64'h8000000000000000, 32'h00000000, 1'b0, 1'b0},
        {2'd2, 64'h7FF0000000000000, 32'h80000000, 1'b1, 1'b0},
        {2'd0, 64'hC1DFFFFFFFC00000, 32'h80000001, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference conversion in real arithmetic
    task automatic ref_cvt(input logic [63:0] b, input logic [1:0] rc,
                           output logic [31:0] res, output logic inv, output logic inx);
        real x, fl, fr, r;
        if (b[62:52] == 11'h7FF) begin
            res = 32'h80000000; inv = 1'b1; inx = 1'b0;
            return;
        end
        x  = $bitstoreal(b);
        fl = $floor(x);
        fr = x - fl;
        case (rc)
            2'd0: begin
                if (fr > 0.5) r = fl + 1.0;
                else if (fr < 0.5) r = fl;
                else r = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
            end
            2'd1: r = fl;
            2'd2: r = (fr != 0.0) ? fl + 1.0 : fl;
            default: r = (x < 0.0) ? $ceil(x) : fl;
        endcase
        if (r > 2147483647.0 || r < -2147483648.0) begin
            res = 32'h80000000; inv = 1'b1; inx = 1'b0;
        end else begin
            res = 32'($rtoi(r)); inv = 1'b0; inx = (fr != 0.0);
        end
    endtask

    task automatic run_op(input logic [1:0] md, input logic [1:0] rc,
                          input logic msk, input logic [255:0] src);
        @(negedge clk);
        in_valid = 1'b1; in_mode = md; in_rc = rc; in_inv_mask = msk; in_src = src;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [255:0] src, expd;
        logic [31:0]  er;
        logic         ei, ex, oi, ox;

        repeat (3) @(negedge clk);
        // R13 reset state
        check(!out_valid && out_we == 2'b00 && !out_fault, "R13", "during reset",
              {out_valid, out_we, out_fault}, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && out_we == 2'b00 && !out_flag_inv && !out_flag_pe, "R13",
              "after reset", {out_valid, out_we, out_flag_inv, out_flag_pe}, 256'd0);

        // Vector table: each entry placed in one lane of a four-lane op (R2, R4, R5)
        for (int i = 0; i < NV; i++) begin
            int ln;
            ln   = i % 4;
            src  = '0;
            src[ln*64 +: 64] = VTAB[i][97:34];
            expd = '0;
            expd[ln*32 +: 32] = VTAB[i][33:2];
            run_op(2'b10, VTAB[i][99:98], 1'b1, src);
            check(out_dst == expd, "R2", $sformatf("vector %0d dst", i), out_dst, expd);
            check(out_flag_inv == VTAB[i][1], "R4", $sformatf("vector %0d invalid", i),
                  {255'd0, out_flag_inv}, {255'd0, VTAB[i][1]});
            check(out_flag_pe == VTAB[i][0], "R3", $sformatf("vector %0d precision", i),
                  {255'd0, out_flag_pe}, {255'd0, VTAB[i][0]});
        end

        // R6 and R9: keep-upper two-lane mode with NaN in the inactive lanes
        src = {D_NAN, D_NAN, D_M2, D_ONE};
        expd = {192'd0, 32'hFFFFFFFE, 32'h00000001};
        run_op(2'b00, 2'b00, 1'b1, src);
        check(out_dst == expd, "R6", "keep2 dst", out_dst, expd);
        check(out_we == 2'b01, "R6", "keep2 we", {254'd0, out_we}, 256'd1);
        check(!out_flag_inv && !out_flag_pe && !out_fault, "R9", "keep2 flags",
              {out_flag_inv, out_flag_pe, out_fault}, 256'd0);

        // R7 and R9: zero-upper two-lane mode
        run_op(2'b01, 2'b00, 1'b1, src);
        check(out_dst == expd, "R7", "zero2 dst", out_dst, expd);
        check(out_we == 2'b11, "R7", "zero2 we", {254'd0, out_we}, 256'd3);
        check(!out_flag_inv && !out_fault, "R9", "zero2 flags",
              {out_flag_inv, out_fault}, 256'd0);

        // R8 and R1: four-lane mode
        src = {D_M7, D_3, D_M2, D_ONE};
        expd = {128'd0, 32'hFFFFFFF9, 32'h00000003, 32'hFFFFFFFE, 32'h00000001};
        run_op(2'b10, 2'b11, 1'b1, src);
        check(out_dst == expd, "R1", "wide4 dst", out_dst, expd);
        check(out_we == 2'b11, "R8", "wide4 we", {254'd0, out_we}, 256'd3);

        // R12: result drops one cycle after the strobe ends
        @(negedge clk);
        check(!out_valid && out_we == 2'b00, "R12", "idle after op",
              {out_valid, out_we}, 256'd0);

        // R10: unmasked invalid suppresses the write
        src = {D_ONE, D_ONE, D_NAN, D_ONE};
        run_op(2'b10, 2'b00, 1'b0, src);
        check(out_fault && out_we == 2'b00 && out_dst == '0, "R10", "unmasked fault",
              {out_fault, out_we, out_dst[200:0]}, {1'b1, 2'b00, 201'd0});
        check(out_flag_inv, "R10", "unmasked inv flag", {255'd0, out_flag_inv}, 256'd1);

        // R4: masked counterpart returns indefinite in lane 1
        run_op(2'b10, 2'b00, 1'b1, src);
        expd = {128'd0, 32'h1, 32'h1, 32'h80000000, 32'h1};
        check(out_dst == expd && !out_fault && out_we == 2'b11, "R4", "masked indefinite",
              out_dst, expd);

        // R11: reserved mode
        run_op(2'b11, 2'b00, 1'b1, src);
        check(out_fault && out_we == 2'b00 && !out_flag_inv && !out_flag_pe, "R11",
              "reserved mode", {out_fault, out_we, out_flag_inv, out_flag_pe},
              {1'b1, 2'b00, 2'b00});

        // R3: flags OR across lanes
        src = {D_NAN, D_ONE, D_ONE, D_HALF};
        run_op(2'b10, 2'b00, 1'b1, src);
        check(out_flag_inv && out_flag_pe, "R3", "flag OR",
              {out_flag_inv, out_flag_pe}, 256'd3);

        // R12: back-to-back operations
        @(negedge clk);
        in_valid = 1'b1; in_mode = 2'b10; in_rc = 2'b00; in_inv_mask = 1'b1;
        in_src = {D_ONE, D_ONE, D_ONE, D_ONE};
        @(negedge clk);
        check(out_valid && out_dst[31:0] == 32'h1, "R12", "first of pair",
              {out_valid, out_dst[31:0]}, {1'b1, 32'h1});
        in_src = {D_3, D_3, D_3, D_3};
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_dst[31:0] == 32'h3, "R12", "second of pair",
              {out_valid, out_dst[31:0]}, {1'b1, 32'h3});

        // R2: random operands in all rounding modes against the reference
        for (int k = 0; k < 160; k++) begin
            logic [1:0] rc;
            logic       fi, fx;
            rc = 2'(k % 4);
            fi = 1'b0; fx = 1'b0;
            for (int j = 0; j < 4; j++) begin
                logic [63:0] v;
                logic [10:0] e;
                e = 11'(1019 + ($urandom % 40));
                v = {1'($urandom), e, 20'($urandom), 32'($urandom)};
                if ($urandom % 3 == 0) v[30:0] = '0;
                src[j*64 +: 64] = v;
            end
            run_op(2'b10, rc, 1'b1, src);
            for (int j = 0; j < 4; j++) begin
                ref_cvt(src[j*64 +: 64], rc, er, ei, ex);
                fi |= ei; fx |= ex;
                check(out_dst[j*32 +: 32] == er, "R2", $sformatf("random %0d lane %0d", k, j),
                      {224'd0, out_dst[j*32 +: 32]}, {224'd0, er});
            end
            oi = out_flag_inv; ox = out_flag_pe;
            check(oi == fi && ox == fx, "R3", $sformatf("random %0d flags", k),
                  {254'd0, oi, ox}, {254'd0, fi, fx});
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule